// File: doc/BRIEF.md
# Voice Trigger Mode Controller

This block sits between five active-high trigger inputs and a sentence player. It decides when a sentence should start, restart or stop. Input 0 is a single stand-alone key. Inputs 1 to 4 are column inputs 0 to 3. Each input has its own settings for debounce speed, edge or level behaviour, hold or unhold, retrigger or irretrigger, and last-key or first-key precedence.

Each raw input passes through a two-flop synchronizer and then a debounce counter that advances on a sample tick. A fixed-priority picker chooses among debounced rising edges that arrive in the same cycle. A controller then compares that choice with the input that owns the current sentence and with the player's busy state. It issues a one-cycle start request, together with the chosen input index, or a one-cycle stop request.

A per-input keep flag applies to inputs set to fast debounce and irretrigger. While the player is busy and the flag is low, such an input is treated as slow debounce with retrigger. The player reports `busy` and gives a one-cycle `sent_end` pulse when a sentence completes. It is expected to raise `busy` in the cycle after `start_req`. It must drop `busy` after a `stop_req`.

Top module: `voice_trig_ctrl`

## Requirements
- R1: An input's debounced level changes only after its synchronized level has differed from it for FAST_TICKS consecutive `tick` cycles (fast debounce) or SLOW_TICKS of them (slow debounce). Any return to the old level restarts the count, and with `tick` low the level never changes.
- R2: While the player is idle, a debounced rising edge produces one `start_req` pulse with `start_idx` equal to the input index (0 = single key, 1..4 = columns 0..3). In edge mode the length of the press has no further effect.
- R3: In level mode, each `sent_end` seen while the owning input is still pressed produces a new `start_req` for that input. After release, the sentence that is playing finishes and no further start follows.
- R4: In hold mode, release of the owning input while busy produces one `stop_req`. In unhold mode no `stop_req` is produced. `stop_req` occurs only while busy.
- R5: While busy, a new press of the owning input restarts the sentence if that input is in retrigger mode, and is ignored if it is in irretrigger mode.
- R6: Simultaneous rising edges resolve with priority column 3 > column 2 > column 1 > column 0 > single key.
- R7: While busy, a press on a different input that is in last-key mode and retrigger mode starts that input's sentence.
- R8: While busy, a press on a different input set to first-key mode (`cfg_lastkey` bit = 0) is ignored.
- R9: An input configured as fast debounce with irretrigger behaves as slow debounce with retrigger while busy and its `keep_mode` bit is 0. With the bit at 1, its configured modes apply.
- R10: After reset `start_req`, `stop_req` and `start_idx` are 0, and `start_req` and `stop_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-rate enable for debounce counting |
| trig_in | input | N_IN | Raw triggers, bit 0 single key, bits 1..4 columns 0..3 |
| cfg_slow | input | N_IN | 1 = slow debounce per input |
| cfg_level | input | N_IN | 1 = level mode, 0 = edge mode |
| cfg_hold | input | N_IN | 1 = hold mode, 0 = unhold |
| cfg_retrig | input | N_IN | 1 = retrigger, 0 = irretrigger |
| cfg_lastkey | input | N_IN | 1 = last-key precedence, 0 = first-key |
| keep_mode | input | N_IN | Keep flag for fast irretrigger inputs while busy |
| busy | input | 1 | Player is playing a sentence |
| sent_end | input | 1 | One-cycle pulse at sentence completion |
| start_req | output | 1 | One-cycle request to start the sentence of `start_idx` |
| start_idx | output | IDX_W | Input whose sentence is requested or playing |
| stop_req | output | 1 | One-cycle request to stop playback |

## Verification
The hardest case to reach from the ports is the forced mode switch. It needs an input that is still pressed or being debounced while the player stays busy for longer than the slow debounce window. The bench therefore lengthens the modelled sentence well beyond SLOW_TICKS. It first shows that a short second press inside that window is ignored, then shows that a long one restarts playback. It repeats the same sequence with the keep flag set, to show that the configured irretrigger behaviour stays in force. Level-mode replay and hold-mode stops are reached through a small player model in the bench that answers start requests with a fixed sentence length.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  typedef struct packed {
    logic slow;
    logic retrig;
  } eff_mode_t;

  // A fast irretrigger input switches to slow retrigger while busy unless kept.
  function automatic eff_mode_t eff_mode(input logic slow, input logic retrig,
                                         input logic busy, input logic keep);
    eff_mode_t m;
    logic forced;
    forced   = !slow && !retrig && busy && !keep;
    m.slow   = slow | forced;
    m.retrig = retrig | forced;
    return m;
  endfunction
endpackage

// File: rtl/vtc_debounce.sv
module vtc_debounce #(
  parameter int FAST_TICKS = 2,
  parameter int SLOW_TICKS = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  input  logic use_slow,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(SLOW_TICKS + 1);

  logic [1:0]    sy;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = use_slow ? CW'(SLOW_TICKS) : CW'(FAST_TICKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy    <= '0;
      cnt   <= '0;
      level <= 1'b0;
      rise  <= 1'b0;
      fall  <= 1'b0;
    end else begin
      sy   <= {sy[0], din};
      rise <= 1'b0;
      fall <= 1'b0;
      if (sy[1] == level) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt + CW'(1) >= lim) begin
          level <= sy[1];
          rise  <= sy[1];
          fall  <= !sy[1];
          cnt   <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R1
  level_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> ($past(tick) && ($past(sy[1]) == level)));
endmodule

// File: rtl/vtc_prio.sv
module vtc_prio #(
  parameter int N_IN  = 5,
  parameter int IDX_W = 3
) (
  input  logic [N_IN-1:0]  req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Highest index wins: later loop iterations override earlier ones.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/voice_trig_ctrl.sv
module voice_trig_ctrl
  import vtc_pkg::*;
#(
  parameter int N_IN       = 5,
  parameter int FAST_TICKS = 2,
  parameter int SLOW_TICKS = 96,
  localparam int IDX_W     = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [N_IN-1:0]  trig_in,
  input  logic [N_IN-1:0]  cfg_slow,
  input  logic [N_IN-1:0]  cfg_level,
  input  logic [N_IN-1:0]  cfg_hold,
  input  logic [N_IN-1:0]  cfg_retrig,
  input  logic [N_IN-1:0]  cfg_lastkey,
  input  logic [N_IN-1:0]  keep_mode,
  input  logic             busy,
  input  logic             sent_end,
  output logic             start_req,
  output logic [IDX_W-1:0] start_idx,
  output logic             stop_req
);
  logic [N_IN-1:0]  lvl, rise, fall, eff_slow, eff_retrig;
  logic             busy_eff;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic [IDX_W-1:0] owner;
  logic             nxt_start, nxt_stop;
  logic [IDX_W-1:0] nxt_idx;

  // A start just issued counts as busy until the player answers.
  assign busy_eff = busy | start_req;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    eff_mode_t m;
    assign m             = eff_mode(cfg_slow[i], cfg_retrig[i], busy_eff, keep_mode[i]);
    assign eff_slow[i]   = m.slow;
    assign eff_retrig[i] = m.retrig;

    vtc_debounce #(.FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS)) u_deb (
      .clk(clk), .rst_n(rst_n), .tick(tick), .din(trig_in[i]),
      .use_slow(eff_slow[i]), .level(lvl[i]), .rise(rise[i]), .fall(fall[i])
    );
  end

  vtc_prio #(.N_IN(N_IN), .IDX_W(IDX_W)) u_prio (
    .req(rise), .any(pick_any), .idx(pick_idx)
  );

  always_comb begin
    nxt_start = 1'b0;
    nxt_stop  = 1'b0;
    nxt_idx   = owner;
    if (pick_any) begin
      if (!busy_eff) begin
        nxt_start = 1'b1;
      end else if (pick_idx == owner) begin
        nxt_start = eff_retrig[pick_idx];
      end else begin
        nxt_start = cfg_lastkey[pick_idx] && eff_retrig[pick_idx];
      end
      if (nxt_start) nxt_idx = pick_idx;
    end
    if (!nxt_start) begin
      if (busy_eff && cfg_hold[owner] && fall[owner]) begin
        nxt_stop = 1'b1;
      end else if (sent_end && cfg_level[owner] && lvl[owner]) begin
        nxt_start = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_req <= 1'b0;
      stop_req  <= 1'b0;
      owner     <= '0;
    end else begin
      start_req <= nxt_start;
      stop_req  <= nxt_stop;
      if (nxt_start) owner <= nxt_idx;
    end
  end

  assign start_idx = owner;

  // R10
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_req && stop_req));

  // R4
  stop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> $past(busy | start_req));

  // R8
  first_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && $past(busy) && (start_idx != $past(start_idx)))
      |-> ((($past(cfg_lastkey) >> start_idx) & N_IN'(1)) != '0));
endmodule

// File: tb/voice_trig_ctrl_tb.sv
module voice_trig_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int N = 5;

  typedef struct packed {
    logic [2:0]  idx;
    logic        lvl;
    logic        hld;
    logic        rtg;
    logic [15:0] len;
    logic [3:0]  st;
    logic [3:0]  sp;
  } vec_t;

  // idx, level, hold, retrig, press length, expected starts, expected stops
  localparam vec_t VECS [6] = '{
    '{3'd0, 1'b0, 1'b0, 1'b0, 16'd20,  4'd1, 4'd0},
    '{3'd2, 1'b0, 1'b0, 1'b0, 16'd200, 4'd1, 4'd0},
    '{3'd3, 1'b0, 1'b1, 1'b0, 16'd20,  4'd1, 4'd1},
    '{3'd1, 1'b1, 1'b0, 1'b0, 16'd150, 4'd3, 4'd0},
    '{3'd4, 1'b1, 1'b1, 1'b0, 16'd150, 4'd3, 4'd1},
    '{3'd0, 1'b1, 1'b0, 1'b0, 16'd20,  4'd1, 4'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [N-1:0] trig_in = '0, cfg_slow = '0, cfg_level = '0, cfg_hold = '0;
  logic [N-1:0] cfg_retrig = '0, cfg_lastkey = '1, keep_mode = '1;
  logic busy, sent_end, start_req, stop_req;
  logic [2:0] start_idx;

  int slen = 60;
  int pcnt;
  int n_start = 0, n_stop = 0, last_idx = 0;
  int checks = 0, errors = 0;

  always #(CLK_P / 2) clk = ~clk;

  voice_trig_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig_in(trig_in),
    .cfg_slow(cfg_slow), .cfg_level(cfg_level), .cfg_hold(cfg_hold),
    .cfg_retrig(cfg_retrig), .cfg_lastkey(cfg_lastkey), .keep_mode(keep_mode),
    .busy(busy), .sent_end(sent_end), .start_req(start_req),
    .start_idx(start_idx), .stop_req(stop_req)
  );

  // Player model: busy the cycle after a start, fixed sentence length.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; sent_end <= 1'b0; pcnt <= 0;
    end else begin
      sent_end <= 1'b0;
      if (start_req) begin
        busy <= 1'b1; pcnt <= slen;
      end else if (stop_req) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (pcnt <= 1) begin busy <= 1'b0; sent_end <= 1'b1; end
        else pcnt <= pcnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && start_req) begin n_start++; last_idx = int'(start_idx); end
    if (rst_n && stop_req) n_stop++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic press(input int idx, input int cyc);
    @(negedge clk); trig_in[idx] = 1'b1;
    repeat (cyc) @(negedge clk);
    trig_in[idx] = 1'b0;
  endtask

  task automatic gap(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  task automatic wait_idle();
    int g = 0;
    repeat (5) @(negedge clk);
    while ((busy || start_req) && g < 5000) begin @(negedge clk); g++; end
    if (g >= 5000) chk(1'b0, "idle timeout", g, 0);
    repeat (120) @(negedge clk);
  endtask

  task automatic set_all(input logic [N-1:0] slw, input logic [N-1:0] rtg,
                         input logic [N-1:0] lk, input logic [N-1:0] kp);
    cfg_slow = slw; cfg_retrig = rtg; cfg_lastkey = lk; keep_mode = kp;
    cfg_level = '0; cfg_hold = '0;
  endtask

  initial begin
    #(CLK_P * 190000);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b0, b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(start_req == 1'b0 && stop_req == 1'b0 && start_idx == 3'd0, "R10 reset",
        {start_req, stop_req, start_idx}, 0);
    rst_n = 1'b1;
    gap(5);

    // R2 R3 R4 table of mode vectors
    for (int k = 0; k < 6; k++) begin
      vec_t v;
      v = VECS[k];
      set_all('0, '0, '1, '1);
      cfg_level[v.idx] = v.lvl;
      cfg_hold[v.idx]  = v.hld;
      cfg_retrig[v.idx] = v.rtg;
      b0 = n_start; b1 = n_stop;
      press(int'(v.idx), int'(v.len));
      wait_idle();
      chk(n_start - b0 == int'(v.st), "R2/R3 starts per mode", n_start - b0, int'(v.st));
      chk(n_stop - b1 == int'(v.sp), "R4 stops per mode", n_stop - b1, int'(v.sp));
      chk(last_idx == int'(v.idx), "R2 start_idx", last_idx, int'(v.idx));
    end

    // R6 priority
    set_all('0, '0, '1, '1);
    b0 = n_start;
    @(negedge clk); trig_in = 5'b10101; gap(10); trig_in = '0;
    wait_idle();
    chk(n_start - b0 == 1 && last_idx == 4, "R6 col3 over col1 and key", last_idx, 4);
    @(negedge clk); trig_in = 5'b00011; gap(10); trig_in = '0;
    wait_idle();
    chk(last_idx == 1, "R6 col0 over key", last_idx, 1);

    // R5 retrigger / irretrigger on the owning input
    slen = 200;
    set_all('0, 5'b00100, '1, '1);
    b0 = n_start;
    press(2, 10); gap(30); press(2, 10);
    wait_idle();
    chk(n_start - b0 == 2, "R5 retrigger restarts", n_start - b0, 2);
    set_all('0, '0, '1, '1);
    b0 = n_start;
    press(2, 10); gap(30); press(2, 10);
    wait_idle();
    chk(n_start - b0 == 1, "R5 irretrigger ignored", n_start - b0, 1);

    // R7 last-key interrupts
    set_all('0, 5'b01010, '1, '1);
    b0 = n_start;
    press(1, 10); gap(30); press(3, 10);
    wait_idle();
    chk(n_start - b0 == 2 && last_idx == 3, "R7 last-key takeover", last_idx, 3);

    // R8 first-key ignores other input
    set_all('0, 5'b01010, 5'b10111, '1);
    b0 = n_start;
    press(1, 10); gap(30); press(3, 10);
    wait_idle();
    chk(n_start - b0 == 1 && last_idx == 1, "R8 first-key ignored", n_start - b0, 1);

    // R9 forced slow retrigger while busy with keep flag low
    slen = 400;
    set_all('0, '0, '1, 5'b11110);
    b0 = n_start;
    press(0, 10); gap(140); press(0, 10);
    chk(n_start - b0 == 1, "R9 short press under forced slow debounce", n_start - b0, 1);
    gap(40); press(0, 150);
    chk(n_start - b0 == 2, "R9 forced retrigger restarts", n_start - b0, 2);
    wait_idle();
    set_all('0, '0, '1, '1);
    b0 = n_start;
    press(0, 10); gap(140); press(0, 10); gap(40); press(0, 150);
    wait_idle();
    chk(n_start - b0 == 1, "R9 keep flag leaves irretrigger", n_start - b0, 1);

    // R1 slow debounce and tick gating while idle
    slen = 60;
    set_all(5'b00010, '0, '1, '1);
    b0 = n_start;
    press(1, 60); wait_idle();
    chk(n_start - b0 == 0, "R1 press shorter than slow window", n_start - b0, 0);
    press(1, 50); gap(5); press(1, 50); wait_idle();
    chk(n_start - b0 == 0, "R1 bounce restarts count", n_start - b0, 0);
    press(1, 150); wait_idle();
    chk(n_start - b0 == 1, "R1 slow press accepted", n_start - b0, 1);
    set_all('0, '0, '1, '1);
    tick = 1'b0;
    b0 = n_start;
    press(2, 50); gap(20);
    tick = 1'b1;
    wait_idle();
    chk(n_start - b0 == 0, "R1 no tick no change", n_start - b0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule